// File: doc/BRIEF.md
# PS/2 Device-Side Command Receiver

This block lives on the peripheral side of a two-wire PS/2 link and takes in command bytes sent by the host. Both wires are open-collector. The block drives each wire through a pull-low enable and senses the actual level on a separate input.

While the bus is quiet, the block checks the wires once per poll interval. It looks for the request state, in which the clock wire is high and the host holds the data wire low. When it sees that state, the block generates the clock itself. It samples one host bit in the middle of each high phase: eight data bits with the least significant bit first, then an odd-parity bit, then the stop bit. After a good stop bit it acknowledges the frame. It pulls the data wire low while the clock is still high, gives one more clock pulse, and then releases both wires.

The block reports each accepted byte with a one-cycle strobe. It flags a parity mismatch, a stop bit that came late, or a host abort. All timing is given as counts of the system clock, so one netlist can run at any system clock rate.

Top module: `ps2_cmd_rx`

## Requirements
- R1: While reset is held and right after it, both pull enables are low and `cmd_valid`, `err_parity`, `err_frame` and `err_abort` are low.
- R2: With the bus idle (both wires high) or inhibited (clock wire low), the block never pulls the clock. A request state (clock high, data low) makes the block start pulling the clock within POLL_CYC+4 cycles of the clock wire going high.
- R3: Each clock-low phase that the block drives lasts exactly HALF_CYC cycles. A high phase counts only the cycles in which the clock wire actually reads high, so a host that holds the clock low stretches that phase.
- R4: Bits are sampled in the middle of the high phase, the first bit going to bit 0 of the byte. When the nine bits (8 data bits plus parity) hold an odd number of ones and the stop bit is 1, `cmd_byte` shows the byte and `cmd_valid` pulses for one cycle.
- R5: When the nine bits hold an even number of ones and the stop bit is 1, `err_parity` pulses for one cycle, `cmd_valid` stays low, and the acknowledge is still given.
- R6: After an accepted stop bit, the data pull rises while the clock wire is released (high). Exactly one more clock pulse follows with data held low, and then both pulls drop. A normal frame therefore has 11 clock pulses.
- R7: When the stop bit reads 0, the block keeps clocking and sampling until data reads 1. It then pulses `err_frame`, gives no acknowledge and no `cmd_valid`, and releases the wires. A frame whose stop is late by n pulses has 10+n clock pulses.
- R8: If the clock wire stays low for HOLD_CYC cycles during a released phase before the acknowledge pulse, the block pulses `err_abort`, releases both wires at once and reports no byte.
- R9: A host hold shorter than HOLD_CYC only delays the frame. The byte is still received and acknowledged.
- R10: At most one of `cmd_valid`, `err_parity`, `err_frame`, `err_abort` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_clk_i | input | 1 | Sensed level of the PS/2 clock wire |
| line_dat_i | input | 1 | Sensed level of the PS/2 data wire |
| clk_pull_o | output | 1 | 1 pulls the clock wire low |
| dat_pull_o | output | 1 | 1 pulls the data wire low |
| cmd_byte | output | 8 | Last accepted command byte |
| cmd_valid | output | 1 | One-cycle strobe for an accepted byte |
| err_parity | output | 1 | One-cycle strobe for a parity mismatch |
| err_frame | output | 1 | One-cycle strobe for a late stop bit |
| err_abort | output | 1 | One-cycle strobe for a host abort |

## Verification
A bit counter that drifts by one shows up within the same frame. The pulse count on `clk_pull_o` moves away from 11, and the strobe fires on the wrong sample, so the byte is shifted or the parity result is wrong. A faulty phase or hold counter shows up at once in the measured low-phase length. It also shows up as a missing abort, or as a false abort in the stretched frame, both before the frame ends. A wrong acknowledge flag shows up on the next data-pull edge, which then lands while the clock is pulled or in a frame that should carry no acknowledge.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_ACK_LOW,
    ST_ACK_HIGH
  } rx_state_t;

  // data bits + parity bit; the stop bit follows as the last sample
  localparam int unsigned SHIFT_BITS = 9;
  localparam int unsigned STOP_IDX   = 9;
endpackage

// File: rtl/ps2_rx_sync.sv
module ps2_rx_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-2:0], d[i]};
    end
    assign q[i] = sh[STAGES-1];
  end
endmodule

// File: rtl/ps2_rx_count.sv
module ps2_rx_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (clr)     q_d = '0;
    else if (en) q_d = q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> (q == $past(q) + 1'b1));
endmodule

// File: rtl/ps2_rx_shift.sv
module ps2_rx_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       take,
  input  logic       bit_in,
  output logic [7:0] data,
  output logic       par_ok
);
  logic [8:0] sr, sr_d;

  always_comb begin
    sr_d = sr;
    if (clr)       sr_d = '0;
    else if (take) sr_d = {bit_in, sr[8:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= sr_d;
  end

  assign data   = sr[7:0];
  assign par_ok = ^sr;

  // R4
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clr) |=> (sr[8] == $past(bit_in)));
endmodule

// File: rtl/ps2_cmd_rx.sv
module ps2_cmd_rx
  import ps2_rx_pkg::*;
#(
  parameter int HALF_CYC = 5000,
  parameter int POLL_CYC = 1000000,
  parameter int HOLD_CYC = 12500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_clk_i,
  input  logic       line_dat_i,
  output logic       clk_pull_o,
  output logic       dat_pull_o,
  output logic [7:0] cmd_byte,
  output logic       cmd_valid,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_abort
);
  localparam int PH_W   = $clog2(HALF_CYC + 1);
  localparam int POLL_W = $clog2(POLL_CYC + 1);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);
  localparam logic [PH_W-1:0]   PH_END   = PH_W'(HALF_CYC - 1);
  localparam logic [PH_W-1:0]   PH_MID   = PH_W'(HALF_CYC / 2);
  localparam logic [POLL_W-1:0] POLL_END = POLL_W'(POLL_CYC - 1);
  localparam logic [HOLD_W-1:0] HOLD_END = HOLD_W'(HOLD_CYC - 1);

  rx_state_t state_q, state_d;
  logic [3:0] bit_q, bit_d;
  logic over_q, over_d, ack_q, ack_d;
  logic valid_d, perr_d, ferr_d, aerr_d;
  logic [7:0] byte_q, byte_d;
  logic clk_s, dat_s;
  logic [PH_W-1:0]   ph_cnt;
  logic [POLL_W-1:0] poll_cnt;
  logic [HOLD_W-1:0] hold_cnt;
  logic ph_en, ph_clr, poll_hit, hold_en, abort_hit, sample, take;
  logic [7:0] sh_data;
  logic par_ok;

  ps2_rx_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({line_clk_i, line_dat_i}), .q({clk_s, dat_s}));

  assign ph_en = (state_q == ST_LOW) || (state_q == ST_ACK_LOW) ||
                 (state_q == ST_ACK_HIGH) || ((state_q == ST_HIGH) && clk_s);
  assign ph_clr = (state_d != state_q) || (state_q == ST_IDLE);

  ps2_rx_count #(.W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .clr(ph_clr), .en(ph_en), .q(ph_cnt));

  assign poll_hit = (state_q == ST_IDLE) && (poll_cnt == POLL_END);

  ps2_rx_count #(.W(POLL_W)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr((state_q != ST_IDLE) || poll_hit),
    .en(state_q == ST_IDLE), .q(poll_cnt));

  assign hold_en   = (state_q == ST_HIGH) && !clk_s;
  assign abort_hit = hold_en && (hold_cnt == HOLD_END);

  ps2_rx_count #(.W(HOLD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr(!hold_en), .en(hold_en), .q(hold_cnt));

  assign sample = (state_q == ST_HIGH) && clk_s && (ph_cnt == PH_MID);
  assign take   = sample && (bit_q < 4'(STOP_IDX));

  ps2_rx_shift u_shift (
    .clk(clk), .rst_n(rst_n), .clr(state_q == ST_IDLE), .take(take),
    .bit_in(dat_s), .data(sh_data), .par_ok(par_ok));

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    over_d  = over_q;
    ack_d   = ack_q;
    byte_d  = byte_q;
    valid_d = 1'b0;
    perr_d  = 1'b0;
    ferr_d  = 1'b0;
    aerr_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        bit_d  = '0;
        over_d = 1'b0;
        ack_d  = 1'b0;
        if (poll_hit && clk_s && !dat_s) state_d = ST_LOW;
      end
      ST_LOW: begin
        if (ph_cnt == PH_END) state_d = ST_HIGH;
      end
      ST_HIGH: begin
        if (abort_hit) begin
          state_d = ST_IDLE;
          ack_d   = 1'b0;
          aerr_d  = 1'b1;
        end else begin
          if (sample) begin
            if (bit_q < 4'(STOP_IDX)) begin
              bit_d = bit_q + 4'd1;
            end else if (!dat_s) begin
              over_d = 1'b1;
            end else if (over_q) begin
              ferr_d  = 1'b1;
              state_d = ST_IDLE;
            end else begin
              ack_d = 1'b1;
              if (par_ok) begin
                valid_d = 1'b1;
                byte_d  = sh_data;
              end else begin
                perr_d = 1'b1;
              end
            end
          end
          if ((state_d == ST_HIGH) && clk_s && (ph_cnt == PH_END))
            state_d = ack_q ? ST_ACK_LOW : ST_LOW;
        end
      end
      ST_ACK_LOW: begin
        if (ph_cnt == PH_END) state_d = ST_ACK_HIGH;
      end
      ST_ACK_HIGH: begin
        if (ph_cnt == PH_END) begin
          state_d = ST_IDLE;
          ack_d   = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bit_q      <= '0;
      over_q     <= 1'b0;
      ack_q      <= 1'b0;
      byte_q     <= '0;
      cmd_valid  <= 1'b0;
      err_parity <= 1'b0;
      err_frame  <= 1'b0;
      err_abort  <= 1'b0;
    end else begin
      state_q    <= state_d;
      bit_q      <= bit_d;
      over_q     <= over_d;
      ack_q      <= ack_d;
      byte_q     <= byte_d;
      cmd_valid  <= valid_d;
      err_parity <= perr_d;
      err_frame  <= ferr_d;
      err_abort  <= aerr_d;
    end
  end

  assign clk_pull_o = (state_q == ST_LOW) || (state_q == ST_ACK_LOW);
  assign dat_pull_o = ack_q;
  assign cmd_byte   = byte_q;

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, err_parity, err_frame, err_abort}));

  // R6
  ack_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_pull_o) |-> !clk_pull_o);

  // R8
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_abort |-> (!clk_pull_o && !dat_pull_o));

  // R4
  valid_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> dat_pull_o);
endmodule

// File: tb/ps2_cmd_rx_tb.sv
module ps2_cmd_rx_tb;
  localparam int HALF = 8;
  localparam int POLL = 16;
  localparam int HOLD = 20;
  localparam int NV   = 6;
  // {byte, flip parity}
  localparam logic [8:0] VEC [NV] = '{
    {8'hA5, 1'b0}, {8'h00, 1'b0}, {8'hFF, 1'b0},
    {8'h3C, 1'b1}, {8'h80, 1'b0}, {8'h01, 1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_clk_pull = 1'b0, h_dat_pull = 1'b0;
  logic clk_pull, dat_pull, clk_line, dat_line;
  logic [7:0] cmd_byte;
  logic cmd_valid, err_parity, err_frame, err_abort;

  always #4 clk = ~clk;

  assign clk_line = !(clk_pull || h_clk_pull);
  assign dat_line = !(dat_pull || h_dat_pull);

  ps2_cmd_rx #(.HALF_CYC(HALF), .POLL_CYC(POLL), .HOLD_CYC(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_clk_i(clk_line), .line_dat_i(dat_line),
    .clk_pull_o(clk_pull), .dat_pull_o(dat_pull), .cmd_byte(cmd_byte),
    .cmd_valid(cmd_valid), .err_parity(err_parity), .err_frame(err_frame),
    .err_abort(err_abort));

  int errors = 0, checks = 0;
  bit done = 1'b0;
  int n_valid = 0, n_perr = 0, n_ferr = 0, n_abort = 0, n_ack = 0, n_rise = 0;
  int bad_lo = 0, bad_ack_edge = 0, lo_run = 0, last_lo = 0;
  logic [7:0] last_byte = '0;
  logic prev_clk = 1'b0, prev_dat = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_valid) begin n_valid++; last_byte = cmd_byte; end
      if (err_parity) n_perr++;
      if (err_frame)  n_ferr++;
      if (err_abort)  n_abort++;
      if (clk_pull && !prev_clk) n_rise++;
      if (dat_pull && !prev_dat) begin
        n_ack++;
        if (clk_pull) bad_ack_edge++;
      end
      if (clk_pull) lo_run++;
      else if (lo_run != 0) begin
        last_lo = lo_run;
        if (lo_run != HALF) bad_lo++;
        lo_run = 0;
      end
      prev_clk = clk_pull;
      prev_dat = dat_pull;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] d, input bit flip, input int stop_extra,
                       input int abort_at, input int stretch_at, output int wait_cyc);
    logic [9:0] bits;
    bits = {1'b1, (~^d) ^ flip, d};
    @(negedge clk);
    h_clk_pull = 1'b1;
    repeat (30) @(negedge clk);
    h_dat_pull = 1'b1;
    repeat (2) @(negedge clk);
    h_clk_pull = 1'b0;
    wait_cyc = 0;
    while (!clk_pull && wait_cyc < 1000) begin
      @(negedge clk);
      wait_cyc++;
    end
    for (int i = 0; i < 10; i++) begin
      if (i > 0) @(negedge clk_line);
      @(negedge clk);
      h_dat_pull = !bits[i];
      if (i == 9 && stop_extra > 0) h_dat_pull = 1'b1;
      if (i == abort_at) begin
        h_clk_pull = 1'b1;
        repeat (HALF + HOLD + 10) @(negedge clk);
        h_dat_pull = 1'b0;
        @(negedge clk);
        h_clk_pull = 1'b0;
        break;
      end
      if (i == stretch_at) begin
        h_clk_pull = 1'b1;
        repeat (HALF + 5) @(negedge clk);
        h_clk_pull = 1'b0;
      end
    end
    if (abort_at < 0) begin
      for (int j = 0; j < stop_extra; j++) @(negedge clk_line);
      @(negedge clk);
    end
    h_dat_pull = 1'b0;
    repeat (6 * HALF + 40) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int w, v0, p0, f0, a0, k0, r0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!clk_pull && !dat_pull, "R1 pulls in reset", {clk_pull, dat_pull}, 0);
    chk(!cmd_valid && !err_parity && !err_frame && !err_abort, "R1 strobes in reset",
        {cmd_valid, err_parity, err_frame, err_abort}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!clk_pull && !dat_pull, "R1 pulls after reset", {clk_pull, dat_pull}, 0);

    // R2 idle and inhibit: no clock
    r0 = n_rise;
    repeat (3 * POLL) @(negedge clk);
    chk(n_rise == r0, "R2 idle quiet", n_rise - r0, 0);
    h_clk_pull = 1'b1;
    repeat (3 * POLL) @(negedge clk);
    h_dat_pull = 1'b1;
    repeat (3 * POLL) @(negedge clk);
    h_dat_pull = 1'b0;
    @(negedge clk);
    h_clk_pull = 1'b0;
    repeat (3 * POLL) @(negedge clk);
    chk(n_rise == r0, "R2 inhibit quiet", n_rise - r0, 0);

    // table: good and bad-parity frames (R4 R5 R6 R3)
    for (int i = 0; i < NV; i++) begin
      v0 = n_valid; p0 = n_perr; k0 = n_ack; r0 = n_rise;
      frame(VEC[i][8:1], VEC[i][0], 0, -1, -1, w);
      chk(w <= POLL + 4, "R2 request latency", w, POLL + 4);
      if (!VEC[i][0]) begin
        chk(n_valid == v0 + 1, "R4 valid strobe", n_valid - v0, 1);
        chk(last_byte == VEC[i][8:1], "R4 byte", last_byte, VEC[i][8:1]);
        chk(n_perr == p0, "R5 no parity error", n_perr - p0, 0);
      end else begin
        chk(n_perr == p0 + 1, "R5 parity error", n_perr - p0, 1);
        chk(n_valid == v0, "R5 no valid", n_valid - v0, 0);
      end
      chk(n_ack == k0 + 1, "R6 one ack", n_ack - k0, 1);
      chk(n_rise == r0 + 11, "R6 pulse count", n_rise - r0, 11);
      chk(!clk_pull && !dat_pull, "R6 released", {clk_pull, dat_pull}, 0);
      chk(last_lo == HALF, "R3 low phase", last_lo, HALF);
    end

    // R7 late stop bit, two extra pulses
    v0 = n_valid; f0 = n_ferr; k0 = n_ack; r0 = n_rise;
    frame(8'h5A, 1'b0, 2, -1, -1, w);
    chk(n_ferr == f0 + 1, "R7 frame error", n_ferr - f0, 1);
    chk(n_rise == r0 + 12, "R7 extra pulses", n_rise - r0, 12);
    chk(n_ack == k0 && n_valid == v0, "R7 no ack no valid", n_ack - k0 + n_valid - v0, 0);
    chk(!clk_pull && !dat_pull, "R7 released", {clk_pull, dat_pull}, 0);

    // R8 abort at bit 4
    v0 = n_valid; a0 = n_abort; k0 = n_ack;
    frame(8'hC3, 1'b0, 0, 4, -1, w);
    chk(n_abort == a0 + 1, "R8 abort flagged", n_abort - a0, 1);
    chk(n_valid == v0 && n_ack == k0, "R8 no byte", n_valid - v0 + n_ack - k0, 0);
    chk(!clk_pull && !dat_pull, "R8 released", {clk_pull, dat_pull}, 0);

    // R9 short hold stretches only
    v0 = n_valid; a0 = n_abort; k0 = n_ack;
    frame(8'h69, 1'b0, 0, -1, 3, w);
    chk(n_abort == a0, "R9 no abort", n_abort - a0, 0);
    chk(n_valid == v0 + 1 && last_byte == 8'h69, "R9 byte kept", last_byte, 8'h69);
    chk(n_ack == k0 + 1, "R9 ack", n_ack - k0, 1);

    // R3 and R6 over the whole run; R10 count consistency
    chk(bad_lo == 0, "R3 all low phases", bad_lo, 0);
    chk(bad_ack_edge == 0, "R6 ack edge while clock high", bad_ack_edge, 0);
    chk(n_valid + n_perr == n_ack, "R10 one strobe per ack", n_valid + n_perr, n_ack);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule